// File: doc/BRIEF.md
# Bus-to-Memory Width Adapter

This block sits between a system bus slave port and an external asynchronous memory with a fixed data width. Each bus request is 8, 16 or 32 bits wide. The block turns it into the external accesses the device can take. When the request is wider than the device, it is split into consecutive accesses. When the request is narrower, it is served either through active-low byte-lane selects or by fetching the whole device word and keeping one byte. Requests the device cannot carry out are refused with an error response, and no external access is made for them.

Two configuration inputs describe the device. The first gives its data width (8 or 16 bits). The second says whether it has byte-lane selects. These inputs are latched together with each request. The external side is a simple port with one access per cycle: address, write data, two byte-lane selects, and chip-select, write and output-enable strobes. Read data is sampled at the end of each access cycle. All logic runs on the single bus clock.

Top module: `memWidthAdapter`

## Requirements
- R1: While reset is held and right after it, `respReady` and `respError` are 0, `memCsN`, `memWeN` and `memOeN` are 1, and `memLaneN` is 2'b11.
- R2: When the request width equals the device width, exactly one external access is made. For such an access on a 16-bit device, both lanes are active (`memLaneN`=2'b00).
- R3: A request wider than the device is split into size/device-width accesses in consecutive cycles, lowest address first. The address steps by 1 on an 8-bit device and by 2 on a 16-bit device. On a 16-bit device the first address is the request address with bit 0 cleared.
- R4: Read data is assembled little-endian and zero-extended, and is presented on `respRdata`. `respReady` is high for exactly one cycle, in the cycle after the last access. A write, or an error, returns `respRdata`=0.
- R5: A byte request to a 16-bit device with byte selects makes one access. Only the addressed lane is enabled: `memLaneN[0]` carries even bytes (data bits 7:0) and `memLaneN[1]` carries odd bytes (bits 15:8). Write data carries the byte on both halves. An 8-bit device always drives `memLaneN`=2'b10.
- R6: A byte write (`reqSize`=0) to a 16-bit device without byte selects makes no external access and ends with an error response. Memory contents are left unchanged.
- R7: A byte read from a 16-bit device without byte selects reads the full word with both lanes active. It returns the addressed byte in `respRdata[7:0]`.
- R8: A 16-bit request (`reqSize`=1) with address bit 0 set is an error. So is a 32-bit request (`reqSize`=2) with either of address bits 1:0 set, and any request with `reqSize`=3. None of these makes an external access.
- R9: An error response raises `respReady` and `respError` together for exactly one cycle, in the cycle after the request is accepted.
- R10: `memCsN` is low exactly during access cycles. During an access, `memWeN` is low for writes and `memOeN` is low for reads, and the two are never low together.
- R11: A request is accepted only while the block is idle. `reqValid` raised during a transfer is ignored and causes no access and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the external access clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgDev16 | input | 1 | 1: device is 16 bits wide, 0: 8 bits wide |
| cfgByteSel | input | 1 | 1: device has byte-lane selects |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqWrite | input | 1 | 1: write, 0: read |
| reqSize | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit, 3: reserved |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqWdata | input | 32 | Write data, right-justified |
| respReady | output | 1 | One-cycle completion pulse |
| respError | output | 1 | Error flag, valid with respReady |
| respRdata | output | 32 | Read data, valid with respReady |
| memAddr | output | ADDR_W | External byte address |
| memWdata | output | 16 | External write data |
| memRdata | input | 16 | External read data |
| memLaneN | output | 2 | Active-low byte-lane selects |
| memCsN | output | 1 | Active-low chip select |
| memWeN | output | 1 | Active-low write strobe |
| memOeN | output | 1 | Active-low output enable |

## Verification
The bench targets several corner cases, and each one shows a specific failure:
- Byte writes to a 16-bit device without lane selects: a design that lets them through would corrupt the neighbouring byte. The bench reads that byte back afterwards to catch this.
- Odd-byte lane selection and byte extraction: a swapped lane or the wrong half returns the even byte in place of the odd one.
- Splitting on an 8-bit device: an error in the address step, part count or byte order shows up as a wrong first or last address, a wrong access count or scrambled data.
- Misaligned and reserved sizes, and a request raised while busy: a design that decodes these badly makes stray accesses, which show up in the access count and latency.

// File: rtl/memAdaptPkg.sv
package memAdaptPkg;
  localparam int BUS_W     = 32;
  localparam int BUS_BYTES = BUS_W / 8;
  localparam int DEV_W     = 16;
  localparam int PART_W    = $clog2(BUS_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } reqSize_e;

  typedef struct packed {
    logic              load;
    logic              active;
    logic [PART_W-1:0] partIdx;
  } strobes_t;
endpackage

// File: rtl/memAdaptCtrl.sv
module memAdaptCtrl
  import memAdaptPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqIllegal,
  input  logic     lastPart,
  output strobes_t strb,
  output logic     respReady,
  output logic     respError
);
  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_DONE, ST_ERROR} state_e;

  state_e            state;
  logic [PART_W-1:0] partQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      partQ <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          partQ <= '0;
          if (reqValid) state <= reqIllegal ? ST_ERROR : ST_ACCESS;
        end
        ST_ACCESS: begin
          if (lastPart) state <= ST_DONE;
          else          partQ <= partQ + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load    = (state == ST_IDLE) && reqValid;
    strb.active  = (state == ST_ACCESS);
    strb.partIdx = partQ;
    respReady    = (state == ST_DONE) || (state == ST_ERROR);
    respError    = (state == ST_ERROR);
  end

  // R3: each non-final part is followed by the next part index
  a_r3_part_advance: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACCESS && !lastPart) |=> (state == ST_ACCESS && partQ == $past(partQ) + 1'b1));

  // R9: an error response lasts one cycle and returns to idle
  a_r9_err_single: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERROR) |=> (state == ST_IDLE));
endmodule

// File: rtl/memAdaptPath.sv
module memAdaptPath
  import memAdaptPkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic              cfgDev16,
  input  logic              cfgByteSel,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BUS_W-1:0]  reqWdata,
  output logic              reqIllegal,
  output logic              lastPart,
  output logic [BUS_W-1:0]  respRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DEV_W-1:0]  memWdata,
  input  logic [DEV_W-1:0]  memRdata,
  output logic [1:0]        memLaneN,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN
);
  localparam int DEV_BYTES = DEV_W / 8;

  logic              lWrite, lDev16, lBsel;
  logic [1:0]        lSize;
  logic [ADDR_W-1:0] lAddr;
  logic [BUS_W-1:0]  lWdata;
  logic [BUS_W-1:0]  acc;

  // Request decode on live inputs, used at acceptance
  always_comb begin
    unique case (reqSize)
      SZ_BYTE: reqIllegal = reqWrite && cfgDev16 && !cfgByteSel;
      SZ_HALF: reqIllegal = reqAddr[0];
      SZ_WORD: reqIllegal = |reqAddr[1:0];
      default: reqIllegal = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lWrite <= 1'b0;
      lDev16 <= 1'b0;
      lBsel  <= 1'b0;
      lSize  <= '0;
      lAddr  <= '0;
      lWdata <= '0;
    end else if (strb.load) begin
      lWrite <= reqWrite;
      lDev16 <= cfgDev16;
      lBsel  <= cfgByteSel;
      lSize  <= reqSize;
      lAddr  <= reqAddr;
      lWdata <= reqWdata;
    end
  end

  // Number of parts from latched request
  logic [PART_W:0] numParts;
  always_comb begin
    if (lDev16) numParts = (lSize == SZ_WORD) ? (PART_W+1)'(BUS_BYTES / DEV_BYTES) : (PART_W+1)'(1);
    else if (lSize == SZ_WORD) numParts = (PART_W+1)'(BUS_BYTES);
    else if (lSize == SZ_HALF) numParts = (PART_W+1)'(2);
    else numParts = (PART_W+1)'(1);
  end
  assign lastPart = ({1'b0, strb.partIdx} == numParts - 1'b1);

  // Address generation
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] partOffset;
  always_comb begin
    baseAddr   = lDev16 ? {lAddr[ADDR_W-1:1], 1'b0} : lAddr;
    partOffset = ADDR_W'(strb.partIdx) << lDev16;
    memAddr    = baseAddr + partOffset;
  end

  // Write data and lane selects
  logic narrowLane;
  assign narrowLane = lDev16 && lBsel && (lSize == SZ_BYTE);

  always_comb begin
    if (!lDev16)              memWdata = {8'h00, lWdata[8*strb.partIdx +: 8]};
    else if (lSize == SZ_BYTE) memWdata = {lWdata[7:0], lWdata[7:0]};
    else                      memWdata = lWdata[16*strb.partIdx[0] +: 16];

    if (!strb.active)   memLaneN = 2'b11;
    else if (!lDev16)   memLaneN = 2'b10;
    else if (narrowLane) memLaneN = lAddr[0] ? 2'b01 : 2'b10;
    else                memLaneN = 2'b00;

    memCsN = !strb.active;
    memWeN = !(strb.active && lWrite);
    memOeN = !(strb.active && !lWrite);
  end

  // Per-byte read capture into the response register
  for (genvar b = 0; b < BUS_BYTES; b++) begin : g_cap
    logic       hit;
    logic [7:0] src;
    always_comb begin
      if (!lDev16) begin
        hit = (strb.partIdx == PART_W'(b));
        src = memRdata[7:0];
      end else if (lSize == SZ_BYTE) begin
        hit = (b == 0);
        src = lAddr[0] ? memRdata[15:8] : memRdata[7:0];
      end else begin
        hit = (strb.partIdx[0] == 1'((b / DEV_BYTES) % 2));
        src = memRdata[8*(b % DEV_BYTES) +: 8];
      end
    end
    always_ff @(posedge clk) begin
      if (!rstN || strb.load) acc[8*b +: 8] <= 8'h00;
      else if (strb.active && !lWrite && hit) acc[8*b +: 8] <= src;
    end
  end

  assign respRdata = acc;

  // R3: address steps by the device width between parts
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && $past(strb.active) && strb.partIdx != '0)
      |-> (memAddr == $past(memAddr) + (lDev16 ? ADDR_W'(2) : ADDR_W'(1))));

  // R5: at most one lane disabled-pattern while active, never both off
  a_r5_lane_live: assert property (@(posedge clk) disable iff (!rstN)
    strb.active |-> (memLaneN != 2'b11));
endmodule

// File: rtl/memWidthAdapter.sv
module memWidthAdapter
  import memAdaptPkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgDev16,
  input  logic              cfgByteSel,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              respReady,
  output logic              respError,
  output logic [31:0]       respRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWdata,
  input  logic [15:0]       memRdata,
  output logic [1:0]        memLaneN,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN
);
  strobes_t strb;
  logic     reqIllegal, lastPart;

  memAdaptCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqIllegal (reqIllegal),
    .lastPart   (lastPart),
    .strb       (strb),
    .respReady  (respReady),
    .respError  (respError)
  );

  memAdaptPath #(.ADDR_W(ADDR_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cfgDev16   (cfgDev16),
    .cfgByteSel (cfgByteSel),
    .reqWrite   (reqWrite),
    .reqSize    (reqSize),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .reqIllegal (reqIllegal),
    .lastPart   (lastPart),
    .respRdata  (respRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memRdata   (memRdata),
    .memLaneN   (memLaneN),
    .memCsN     (memCsN),
    .memWeN     (memWeN),
    .memOeN     (memOeN)
  );

  // R10: write and read strobes never overlap, and stay off without select
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(!memWeN && !memOeN));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    memCsN |-> (memWeN && memOeN));

  // R4: completion is a single-cycle pulse
  a_r4_ready_pulse: assert property (@(posedge clk) disable iff (!rstN)
    respReady |=> !respReady);

  // R6 / R8: an error response follows a cycle with no access
  a_r6_err_no_access: assert property (@(posedge clk) disable iff (!rstN)
    respError |-> (memCsN && $past(memCsN)));
endmodule

// File: tb/test_memWidthAdapter.sv
module test_memWidthAdapter;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgDev16 = 1'b0, cfgByteSel = 1'b0;
  logic              reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]        reqSize = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [31:0]       reqWdata = '0;
  logic              respReady, respError;
  logic [31:0]       respRdata;
  logic [ADDR_W-1:0] memAddr;
  logic [15:0]       memWdata, memRdata;
  logic [1:0]        memLaneN;
  logic              memCsN, memWeN, memOeN;

  always #(CLK_PERIOD/2) clk = ~clk;

  memWidthAdapter #(.ADDR_W(ADDR_W)) i_memWidthAdapter (
    .clk(clk), .rstN(rstN), .cfgDev16(cfgDev16), .cfgByteSel(cfgByteSel),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSize(reqSize), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .respReady(respReady), .respError(respError), .respRdata(respRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memLaneN(memLaneN),
    .memCsN(memCsN), .memWeN(memWeN), .memOeN(memOeN)
  );

  // Memory model: byte array, one access per cycle
  logic [7:0] mem [256];
  logic       devIs16 = 1'b0;
  logic [7:0] ma;
  assign ma = memAddr[7:0];
  assign memRdata = devIs16 ? {mem[{ma[7:1], 1'b1}], mem[{ma[7:1], 1'b0}]} : {8'h00, mem[ma]};

  always @(posedge clk) begin
    if (!memCsN && !memWeN) begin
      if (devIs16) begin
        if (!memLaneN[0]) mem[{ma[7:1], 1'b0}] <= memWdata[7:0];
        if (!memLaneN[1]) mem[{ma[7:1], 1'b1}] <= memWdata[15:8];
      end else begin
        mem[ma] <= memWdata[7:0];
      end
    end
  end

  int total = 0;
  int bad = 0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Results of one request
  logic              gotErr;
  logic [31:0]       gotRdata;
  int                gotParts, gotLat;
  logic [ADDR_W-1:0] gotFirst, gotLast;
  logic [1:0]        gotLanes;
  logic              gotStrobeBad;

  task automatic doReq(input logic d16, input logic bs, input logic wr, input logic [1:0] sz,
                       input logic [7:0] ad, input logic [31:0] wd);
    @(negedge clk);
    cfgDev16 = d16; cfgByteSel = bs; devIs16 = d16;
    reqWrite = wr; reqSize = sz; reqAddr = {8'h00, ad}; reqWdata = wd; reqValid = 1'b1;
    gotParts = 0; gotLat = 0; gotStrobeBad = 1'b0; gotLanes = 2'b11;
    gotFirst = '0; gotLast = '0;
    while (1) begin
      @(negedge clk);
      reqValid = 1'b0;
      gotLat++;
      if (!memCsN) begin
        if (gotParts == 0) begin gotFirst = memAddr; gotLanes = memLaneN; end
        gotLast = memAddr;
        gotParts++;
        if (wr ? (memWeN || !memOeN) : (!memWeN || memOeN)) gotStrobeBad = 1'b1;
      end else if (!memWeN || !memOeN) gotStrobeBad = 1'b1;
      if (respReady || gotLat > 40) break;
    end
    gotErr = respError;
    gotRdata = respRdata;
  endtask

  typedef struct packed {
    logic        d16;
    logic        bs;
    logic        wr;
    logic [1:0]  sz;
    logic [7:0]  ad;
    logic [31:0] wd;
    logic        eErr;
    logic [2:0]  eParts;
    logic [31:0] eData;
    logic [1:0]  eLanes;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b0,2'd2,8'h10,32'h0,       1'b0,3'd2,32'h13121110,2'b00},
    '{1'b1,1'b1,1'b0,2'd1,8'h22,32'h0,       1'b0,3'd1,32'h00002322,2'b00},
    '{1'b0,1'b0,1'b0,2'd2,8'h30,32'h0,       1'b0,3'd4,32'h33323130,2'b10},
    '{1'b0,1'b0,1'b0,2'd1,8'h41,32'h0,       1'b1,3'd0,32'h0,       2'b11},
    '{1'b1,1'b1,1'b1,2'd0,8'h51,32'hAB,      1'b0,3'd1,32'h0,       2'b01},
    '{1'b1,1'b1,1'b0,2'd1,8'h50,32'h0,       1'b0,3'd1,32'h0000AB50,2'b00},
    '{1'b1,1'b0,1'b1,2'd0,8'h60,32'hAA,      1'b1,3'd0,32'h0,       2'b11},
    '{1'b1,1'b0,1'b0,2'd1,8'h60,32'h0,       1'b0,3'd1,32'h00006160,2'b00},
    '{1'b1,1'b0,1'b0,2'd0,8'h63,32'h0,       1'b0,3'd1,32'h00000063,2'b00},
    '{1'b1,1'b1,1'b0,2'd0,8'h63,32'h0,       1'b0,3'd1,32'h00000063,2'b01},
    '{1'b0,1'b0,1'b1,2'd2,8'h70,32'hDEADBEEF,1'b0,3'd4,32'h0,       2'b10},
    '{1'b1,1'b0,1'b0,2'd2,8'h70,32'h0,       1'b0,3'd2,32'hDEADBEEF,2'b00},
    '{1'b1,1'b1,1'b1,2'd2,8'h82,32'h0,       1'b1,3'd0,32'h0,       2'b11},
    '{1'b1,1'b1,1'b0,2'd3,8'h80,32'h0,       1'b1,3'd0,32'h0,       2'b11},
    '{1'b0,1'b0,1'b1,2'd1,8'h90,32'h1234,    1'b0,3'd2,32'h0,       2'b10},
    '{1'b0,1'b0,1'b0,2'd0,8'h91,32'h0,       1'b0,3'd1,32'h00000012,2'b10},
    '{1'b1,1'b1,1'b1,2'd1,8'hA0,32'hCAFE,    1'b0,3'd1,32'h0,       2'b00},
    '{1'b0,1'b1,1'b0,2'd1,8'hA0,32'h0,       1'b0,3'd2,32'h0000CAFE,2'b10}
  };

  task automatic runVec(input vec_t v);
    logic [ADDR_W-1:0] expFirst, expLast;
    doReq(v.d16, v.bs, v.wr, v.sz, v.ad, v.wd);
    expFirst = v.d16 ? {8'h00, v.ad[7:1], 1'b0} : {8'h00, v.ad};
    expLast  = expFirst + ADDR_W'((int'(v.eParts) - 1) * (v.d16 ? 2 : 1));
    check("R6/R8", "error flag", 32'(gotErr), 32'(v.eErr));
    check("R2/R3", "access count", 32'(gotParts), 32'(v.eParts));
    check("R4/R7", "read data", gotRdata, v.eData);
    check("R9/R4", "latency", 32'(gotLat), v.eErr ? 32'd1 : 32'(v.eParts) + 32'd1);
    check("R10", "strobe usage", 32'(gotStrobeBad), 32'd0);
    if (v.eParts != 0) begin
      check("R5", "lane selects", 32'(gotLanes), 32'(v.eLanes));
      check("R3", "first address", 32'(gotFirst), 32'(expFirst));
      check("R3", "last address", 32'(gotLast), 32'(expLast));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "respReady", 32'(respReady), 32'd0);
    check("R1", "respError", 32'(respError), 32'd0);
    check("R1", "strobes", {29'd0, memCsN, memWeN, memOeN}, 32'h7);
    check("R1", "lanes", 32'(memLaneN), 32'h3);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "strobes after release", {29'd0, memCsN, memWeN, memOeN}, 32'h7);
    check("R1", "ready after release", 32'(respReady), 32'd0);

    for (int i = 0; i < NV; i++) runVec(VECS[i]);

    // R6: rejected write left memory untouched (byte at 0x60 still its pattern)
    doReq(1'b1, 1'b1, 1'b0, 2'd0, 8'h60, 32'h0);
    check("R6", "byte untouched after rejected write", gotRdata, 32'h60);

    // R11: request raised during a transfer is ignored
    @(negedge clk);
    cfgDev16 = 1'b0; cfgByteSel = 1'b0; devIs16 = 1'b0;
    reqWrite = 1'b0; reqSize = 2'd2; reqAddr = 16'h00B0; reqWdata = '0; reqValid = 1'b1;
    begin
      int parts = 0;
      int lat = 0;
      int readies = 0;
      while (1) begin
        @(negedge clk);
        lat++;
        if (lat == 1) begin
          reqWrite = 1'b1; reqSize = 2'd0; reqAddr = 16'h00C0; reqWdata = 32'hFF; reqValid = 1'b1;
        end else reqValid = 1'b0;
        if (!memCsN) parts++;
        if (respReady) begin readies++; break; end
        if (lat > 40) break;
      end
      check("R11", "parts while busy", 32'(parts), 32'd4);
      check("R11", "read data while busy", respRdata, 32'hB3B2B1B0);
      repeat (3) begin
        @(negedge clk);
        if (!memCsN) parts++;
        if (respReady) readies++;
      end
      check("R11", "no extra access", 32'(parts), 32'd4);
      check("R11", "no extra response", 32'(readies), 32'd1);
    end
    doReq(1'b0, 1'b0, 1'b0, 2'd0, 8'hC0, 32'h0);
    check("R11", "ignored write left byte", gotRdata, 32'h000000C0);

    // R5: even-lane byte write on 16-bit device with selects
    doReq(1'b1, 1'b1, 1'b1, 2'd0, 8'hD0, 32'h5C);
    check("R5", "even lane", 32'(gotLanes), 32'h2);
    doReq(1'b1, 1'b1, 1'b0, 2'd1, 8'hD0, 32'h0);
    check("R5", "even byte written odd kept", gotRdata, 32'h0000D15C);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule